// File: doc/BRIEF.md
# Boundary Scan Test Access Port

This block is the test access port of a synchronous memory device. A sixteen-state controller advances on every rising edge of the test clock under the mode-select input. It holds a three-bit instruction register and three data paths: a one-bit bypass stage, a 32-bit identification word and a 69-bit boundary chain. The current instruction decides which of these paths sits between the serial input and the serial output.

The instruction decoder also drives two kinds of control. The first is a high-impedance override for the memory's output drivers. The second is a pair of strobes that mark the capture and update moments of the boundary chain. The pad ring is represented by a parallel vector that the boundary chain samples. The instruction set is not the standard one. Two instructions float the outputs. The sampling instruction captures the pads but never loads anything back onto them. Three codes are reserved and fall back to bypass.

Top module: `scan_tap_top`

## Requirements
- R1: While `rst` is high at a rising edge the controller enters Test-Logic-Reset and the active instruction becomes 001. After reset `tdo_en` is 0 and `out_hiz` is 0.
- R2: Five consecutive rising edges with `tms` high bring the controller to Test-Logic-Reset from any state. It then leaves the serial output disabled, and the next data scan returns the identification word.
- R3: Capture-IR loads 001 into the instruction shift stage. The stage shifts out least significant bit first. The active instruction changes only on the rising edge that leaves Update-IR, or while in Test-Logic-Reset.
- R4: With instruction 001 a data scan returns the identification word least significant bit first. The word is {revision 3'b010 in bits 31:29, 5'b01010 in 28:24, 6'b001001 in 23:18, device 6'b100110 in 17:12, vendor 11'b00000110100 in 11:1, 1 in bit 0}, which is 32'h4A266069.
- R5: Instruction 111 and the reserved codes 011, 101 and 110 select a one-bit bypass stage. Capture-DR loads 0 into it, and each bit on `tdi` reaches `tdo` one shift later. These codes leave `out_hiz` at 0.
- R6: Instruction 000 sets `out_hiz` to 1 and selects the 69-bit boundary chain. Capture-DR loads `io_in` into the chain, bit 0 of which reaches `tdo` first, and a 70th shift returns the first bit that was shifted in.
- R7: Instruction 010 sets `out_hiz` to 1 and captures and shifts the boundary chain in the same way as code 000.
- R8: Instruction 100 captures and shifts the boundary chain with `out_hiz` at 0. Its Update-DR raises no update strobe.
- R9: `bs_capture` is 1 exactly in Capture-DR while a boundary instruction (000, 010 or 100) is active. `bs_update` is 1 exactly in Update-DR while 000 or 010 is active.
- R10: `tdo` and `tdo_en` change only on falling edges of `tck`. `tdo_en` is 1 only in Shift-IR and Shift-DR, and `tdo` reads 0 whenever it is disabled.
- R11: `out_hiz` returns to 0 one rising edge after the controller enters Test-Logic-Reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| tms | input | 1 | Mode select, sampled on rising edges |
| tdi | input | 1 | Serial data in, sampled on rising edges |
| io_in | input | 69 | Parallel pad values seen by the boundary chain |
| tdo | output | 1 | Serial data out, updated on falling edges |
| tdo_en | output | 1 | Output enable for `tdo` |
| out_hiz | output | 1 | Forces the memory output drivers to high impedance |
| bs_capture | output | 1 | Boundary chain capture strobe |
| bs_update | output | 1 | Boundary chain update strobe |

## Verification
A wrong controller state shows up at `tdo_en` or at a strobe. The enable shows it on the falling edge after the bad transition, and a strobe shows it as soon as the state register settles. An instruction register that loads early or decodes wrongly changes `out_hiz` within one clock. It also changes which word comes out of the next scan. Faults in a data path surface bit by bit on `tdo` during the following shift. The bench checks this against its own behavioural model on every cycle, so the fault is reported in the first shift cycle that exposes it.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

    localparam int IR_W  = 3;
    localparam int ID_W  = 32;

    typedef enum logic [3:0] {
        TS_RESET,
        TS_IDLE,
        TS_DR_SEL,
        TS_DR_CAP,
        TS_DR_SHIFT,
        TS_DR_EXIT1,
        TS_DR_PAUSE,
        TS_DR_EXIT2,
        TS_DR_UPD,
        TS_IR_SEL,
        TS_IR_CAP,
        TS_IR_SHIFT,
        TS_IR_EXIT1,
        TS_IR_PAUSE,
        TS_IR_EXIT2,
        TS_IR_UPD
    } tap_state_t;

    typedef logic [IR_W-1:0] opcode_t;

    localparam opcode_t OP_EXTEST  = 3'b000;
    localparam opcode_t OP_IDCODE  = 3'b001;
    localparam opcode_t OP_SAMPLEZ = 3'b010;
    localparam opcode_t OP_SAMPLE  = 3'b100;
    localparam opcode_t OP_BYPASS  = 3'b111;
    localparam opcode_t IR_CAP_PAT = 3'b001;

    typedef enum logic [1:0] {
        PATH_BYPASS,
        PATH_ID,
        PATH_BOUNDARY
    } dr_path_t;

    typedef struct packed {
        dr_path_t path;
        logic     hiz;
        logic     upd_allowed;
    } instr_ctl_t;

    function automatic tap_state_t tap_next(input tap_state_t s, input logic m);
        tap_state_t n;
        case (s)
            TS_RESET:    n = m ? TS_RESET    : TS_IDLE;
            TS_IDLE:     n = m ? TS_DR_SEL   : TS_IDLE;
            TS_DR_SEL:   n = m ? TS_IR_SEL   : TS_DR_CAP;
            TS_DR_CAP:   n = m ? TS_DR_EXIT1 : TS_DR_SHIFT;
            TS_DR_SHIFT: n = m ? TS_DR_EXIT1 : TS_DR_SHIFT;
            TS_DR_EXIT1: n = m ? TS_DR_UPD   : TS_DR_PAUSE;
            TS_DR_PAUSE: n = m ? TS_DR_EXIT2 : TS_DR_PAUSE;
            TS_DR_EXIT2: n = m ? TS_DR_UPD   : TS_DR_SHIFT;
            TS_DR_UPD:   n = m ? TS_DR_SEL   : TS_IDLE;
            TS_IR_SEL:   n = m ? TS_RESET    : TS_IR_CAP;
            TS_IR_CAP:   n = m ? TS_IR_EXIT1 : TS_IR_SHIFT;
            TS_IR_SHIFT: n = m ? TS_IR_EXIT1 : TS_IR_SHIFT;
            TS_IR_EXIT1: n = m ? TS_IR_UPD   : TS_IR_PAUSE;
            TS_IR_PAUSE: n = m ? TS_IR_EXIT2 : TS_IR_PAUSE;
            TS_IR_EXIT2: n = m ? TS_IR_UPD   : TS_IR_SHIFT;
            TS_IR_UPD:   n = m ? TS_DR_SEL   : TS_IDLE;
            default:     n = TS_RESET;
        endcase
        return n;
    endfunction

    function automatic instr_ctl_t decode_op(input opcode_t op);
        instr_ctl_t c;
        c.path        = PATH_BYPASS;
        c.hiz         = 1'b0;
        c.upd_allowed = 1'b0;
        case (op)
            OP_EXTEST, OP_SAMPLEZ: begin
                c.path        = PATH_BOUNDARY;
                c.hiz         = 1'b1;
                c.upd_allowed = 1'b1;
            end
            OP_SAMPLE:  c.path = PATH_BOUNDARY;
            OP_IDCODE:  c.path = PATH_ID;
            default:    c.path = PATH_BYPASS;
        endcase
        return c;
    endfunction

    function automatic logic [ID_W-1:0] build_id(
        input logic [2:0]  rev,
        input logic [4:0]  depth,
        input logic [5:0]  arch,
        input logic [5:0]  dev,
        input logic [10:0] vendor
    );
        return {rev, depth, arch, dev, vendor, 1'b1};
    endfunction

endpackage

// File: rtl/scan_tap_fsm.sv
module scan_tap_fsm
    import scan_tap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tms,
    output tap_state_t state
);

    always_ff @(posedge clk) begin
        if (rst) state <= TS_RESET;
        else     state <= tap_next(state, tms);
    end

    // run length of consecutive high mode-select samples, saturating at 5
    logic [2:0] hi_run;
    always_ff @(posedge clk) begin
        if (rst)                hi_run <= 3'd0;
        else if (!tms)          hi_run <= 3'd0;
        else if (hi_run != 3'd5) hi_run <= hi_run + 3'd1;
    end

    a_r2_five_high_resets: assert property (@(posedge clk) disable iff (rst)
        (hi_run == 3'd5) |-> (state == TS_RESET));

endmodule

// File: rtl/scan_tap_ir.sv
module scan_tap_ir
    import scan_tap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tdi,
    input  tap_state_t state,
    output opcode_t    ir_op,
    output instr_ctl_t ctl,
    output logic       ir_tdo
);

    opcode_t ir_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            ir_sh <= IR_CAP_PAT;
            ir_op <= OP_IDCODE;
        end else begin
            case (state)
                TS_RESET:    ir_op <= OP_IDCODE;
                TS_IR_CAP:   ir_sh <= IR_CAP_PAT;
                TS_IR_SHIFT: ir_sh <= {tdi, ir_sh[IR_W-1:1]};
                TS_IR_UPD:   ir_op <= ir_sh;
                default:     ;
            endcase
        end
    end

    assign ctl    = decode_op(ir_op);
    assign ir_tdo = ir_sh[0];

    a_r3_op_changes_on_update: assert property (@(posedge clk) disable iff (rst)
        !$stable(ir_op) |-> ($past(state) == TS_IR_UPD || $past(state) == TS_RESET));

    a_r3_capture_pattern: assert property (@(posedge clk) disable iff (rst)
        (state == TS_IR_SHIFT && $past(state) == TS_IR_CAP) |-> (ir_sh == IR_CAP_PAT));

    a_r5_reserved_bypass: assert property (@(posedge clk) disable iff (rst)
        (ir_op == 3'b011 || ir_op == 3'b101 || ir_op == 3'b110)
            |-> (ctl.path == PATH_BYPASS && !ctl.hiz));

    a_r11_reset_releases_hiz: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == TS_RESET) |-> !ctl.hiz);

endmodule

// File: rtl/scan_tap_dr.sv
module scan_tap_dr
    import scan_tap_pkg::*;
#(
    parameter int               BSR_W   = 69,
    parameter logic [ID_W-1:0]  ID_WORD = 32'h0000_0001
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tdi,
    input  tap_state_t       state,
    input  dr_path_t         path,
    input  logic [BSR_W-1:0] io_in,
    output logic             dr_tdo
);

    logic             byp_q;
    logic [ID_W-1:0]  id_q;
    logic [BSR_W-1:0] bsr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            byp_q <= 1'b0;
            id_q  <= '0;
            bsr_q <= '0;
        end else if (state == TS_DR_CAP) begin
            case (path)
                PATH_ID:       id_q  <= ID_WORD;
                PATH_BOUNDARY: bsr_q <= io_in;
                default:       byp_q <= 1'b0;
            endcase
        end else if (state == TS_DR_SHIFT) begin
            case (path)
                PATH_ID:       id_q  <= {tdi, id_q[ID_W-1:1]};
                PATH_BOUNDARY: bsr_q <= {tdi, bsr_q[BSR_W-1:1]};
                default:       byp_q <= tdi;
            endcase
        end
    end

    always_comb begin
        case (path)
            PATH_ID:       dr_tdo = id_q[0];
            PATH_BOUNDARY: dr_tdo = bsr_q[0];
            default:       dr_tdo = byp_q;
        endcase
    end

    a_r5_bypass_captures_zero: assert property (@(posedge clk) disable iff (rst)
        (state == TS_DR_SHIFT && $past(state) == TS_DR_CAP && $past(path) == PATH_BYPASS)
            |-> (byp_q == 1'b0));

    a_r4_id_loaded: assert property (@(posedge clk) disable iff (rst)
        (state == TS_DR_SHIFT && $past(state) == TS_DR_CAP && $past(path) == PATH_ID)
            |-> (id_q == ID_WORD));

endmodule

// File: rtl/scan_tap_top.sv
module scan_tap_top
    import scan_tap_pkg::*;
#(
    parameter int          BSR_W     = 69,
    parameter logic [2:0]  ID_REV    = 3'b010,
    parameter logic [4:0]  ID_DEPTH  = 5'b01010,
    parameter logic [5:0]  ID_ARCH   = 6'b001001,
    parameter logic [5:0]  ID_DEV    = 6'b100110,
    parameter logic [10:0] ID_VENDOR = 11'b00000110100
) (
    input  logic             tck,
    input  logic             rst,
    input  logic             tms,
    input  logic             tdi,
    input  logic [BSR_W-1:0] io_in,
    output logic             tdo,
    output logic             tdo_en,
    output logic             out_hiz,
    output logic             bs_capture,
    output logic             bs_update
);

    localparam logic [ID_W-1:0] ID_WORD =
        build_id(ID_REV, ID_DEPTH, ID_ARCH, ID_DEV, ID_VENDOR);

    tap_state_t state;
    opcode_t    ir_op;
    instr_ctl_t ctl;
    logic       ir_tdo;
    logic       dr_tdo;
    logic       shifting;
    logic       serial_bit;

    scan_tap_fsm u_fsm (
        .clk   (tck),
        .rst   (rst),
        .tms   (tms),
        .state (state)
    );

    scan_tap_ir u_ir (
        .clk    (tck),
        .rst    (rst),
        .tdi    (tdi),
        .state  (state),
        .ir_op  (ir_op),
        .ctl    (ctl),
        .ir_tdo (ir_tdo)
    );

    scan_tap_dr #(
        .BSR_W   (BSR_W),
        .ID_WORD (ID_WORD)
    ) u_dr (
        .clk    (tck),
        .rst    (rst),
        .tdi    (tdi),
        .state  (state),
        .path   (ctl.path),
        .io_in  (io_in),
        .dr_tdo (dr_tdo)
    );

    assign shifting   = (state == TS_IR_SHIFT) || (state == TS_DR_SHIFT);
    assign serial_bit = (state == TS_IR_SHIFT) ? ir_tdo : dr_tdo;

    // serial output retimed to the falling edge
    always_ff @(negedge tck) begin
        if (rst) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo    <= shifting & serial_bit;
            tdo_en <= shifting;
        end
    end

    assign out_hiz    = ctl.hiz;
    assign bs_capture = (state == TS_DR_CAP) && (ctl.path == PATH_BOUNDARY);
    assign bs_update  = (state == TS_DR_UPD) && (ctl.path == PATH_BOUNDARY) && ctl.upd_allowed;

    a_r10_enable_tracks_shift: assert property (@(posedge tck) disable iff (rst)
        tdo_en == ((state == TS_IR_SHIFT) || (state == TS_DR_SHIFT)));

    a_r10_idle_output_low: assert property (@(posedge tck) disable iff (rst)
        !tdo_en |-> !tdo);

    a_r8_no_update_on_sample: assert property (@(posedge tck) disable iff (rst)
        bs_update |-> (ir_op != OP_SAMPLE));

    a_r9_strobes_exclusive: assert property (@(posedge tck) disable iff (rst)
        $onehot0({bs_capture, bs_update, tdo_en}));

endmodule

// File: tb/tb_scan_tap_top.sv
module tb_scan_tap_top;

    localparam int PER = 20;
    localparam int BW  = 69;
    localparam logic [31:0] ID_EXP = 32'h4A26_6069;

    localparam int S_TLR = 0,  S_RTI = 1,  S_SDR = 2,  S_CDR = 3;
    localparam int S_SHDR = 4, S_E1DR = 5, S_PDR = 6,  S_E2DR = 7;
    localparam int S_UDR = 8,  S_SIR = 9,  S_CIR = 10, S_SHIR = 11;
    localparam int S_E1IR = 12, S_PIR = 13, S_E2IR = 14, S_UIR = 15;

    logic          tck = 1'b0;
    logic          rst = 1'b1;
    logic          tms = 1'b1;
    logic          tdi = 1'b0;
    logic [BW-1:0] io_in = '0;
    logic          tdo, tdo_en, out_hiz, bs_capture, bs_update;

    scan_tap_top dut (
        .tck        (tck),
        .rst        (rst),
        .tms        (tms),
        .tdi        (tdi),
        .io_in      (io_in),
        .tdo        (tdo),
        .tdo_en     (tdo_en),
        .out_hiz    (out_hiz),
        .bs_capture (bs_capture),
        .bs_update  (bs_update)
    );

    always #(PER/2) tck = ~tck;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    finished = 0;
    string cur_req  = "R1";

    // behavioural reference
    int          m_st = S_TLR;
    logic [2:0]  m_irsh = 3'b001;
    logic [2:0]  m_op = 3'b001;
    logic        m_byp = 1'b0;
    logic [31:0] m_id = '0;
    logic [BW-1:0] m_bsr = '0;
    logic        m_tdo = 1'b0;
    logic        m_en = 1'b0;

    // values sampled at the last compare point
    logic s_tdo, s_en, s_hiz, s_cap, s_upd;

    function automatic int nxt(int s, logic m);
        case (s)
            S_TLR:  return m ? S_TLR  : S_RTI;
            S_RTI:  return m ? S_SDR  : S_RTI;
            S_SDR:  return m ? S_SIR  : S_CDR;
            S_CDR:  return m ? S_E1DR : S_SHDR;
            S_SHDR: return m ? S_E1DR : S_SHDR;
            S_E1DR: return m ? S_UDR  : S_PDR;
            S_PDR:  return m ? S_E2DR : S_PDR;
            S_E2DR: return m ? S_UDR  : S_SHDR;
            S_UDR:  return m ? S_SDR  : S_RTI;
            S_SIR:  return m ? S_TLR  : S_CIR;
            S_CIR:  return m ? S_E1IR : S_SHIR;
            S_SHIR: return m ? S_E1IR : S_SHIR;
            S_E1IR: return m ? S_UIR  : S_PIR;
            S_PIR:  return m ? S_E2IR : S_PIR;
            S_E2IR: return m ? S_UIR  : S_SHIR;
            default: return m ? S_SDR : S_RTI;
        endcase
    endfunction

    function automatic bit m_boundary();
        return (m_op == 3'b000) || (m_op == 3'b010) || (m_op == 3'b100);
    endfunction

    function automatic bit m_floats();
        return (m_op == 3'b000) || (m_op == 3'b010);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [71:0] act, input logic [71:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic model_rise();
        if (rst) begin
            m_st = S_TLR;
            m_op = 3'b001;
            return;
        end
        case (m_st)
            S_TLR:  m_op = 3'b001;
            S_CIR:  m_irsh = 3'b001;
            S_SHIR: m_irsh = {tdi, m_irsh[2:1]};
            S_UIR:  m_op = m_irsh;
            S_CDR: begin
                if (m_boundary())       m_bsr = io_in;
                else if (m_op == 3'b001) m_id = ID_EXP;
                else                    m_byp = 1'b0;
            end
            S_SHDR: begin
                if (m_boundary())       m_bsr = {tdi, m_bsr[BW-1:1]};
                else if (m_op == 3'b001) m_id = {tdi, m_id[31:1]};
                else                    m_byp = tdi;
            end
            default: ;
        endcase
        m_st = nxt(m_st, tms);
    endtask

    task automatic model_fall();
        logic b;
        if (rst) begin
            m_tdo = 1'b0;
            m_en  = 1'b0;
            return;
        end
        if (m_st == S_SHIR)        b = m_irsh[0];
        else if (m_boundary())     b = m_bsr[0];
        else if (m_op == 3'b001)   b = m_id[0];
        else                       b = m_byp;
        m_en  = (m_st == S_SHIR) || (m_st == S_SHDR);
        m_tdo = m_en ? b : 1'b0;
    endtask

    // one test clock: drive, rising edge, falling edge, compare
    task automatic step(input logic m, input logic d);
        logic pre;
        tms = m;
        tdi = d;
        pre = tdo;
        @(posedge tck);
        model_rise();
        #1;
        if (!rst)
            check(tdo === pre, "R10", "tdo moved at rising edge", {71'd0, tdo}, {71'd0, pre});
        @(negedge tck);
        model_fall();
        #(PER/4);
        s_tdo = tdo; s_en = tdo_en; s_hiz = out_hiz; s_cap = bs_capture; s_upd = bs_update;
        if (!rst) begin
            check(tdo_en === m_en, "R10", "tdo_en", {71'd0, tdo_en}, {71'd0, m_en});
            check(tdo === m_tdo, cur_req, "tdo", {71'd0, tdo}, {71'd0, m_tdo});
            check(out_hiz === m_floats(), cur_req, "out_hiz", {71'd0, out_hiz}, {71'd0, m_floats()});
            check(bs_capture === (m_st == S_CDR && m_boundary()), "R9", "bs_capture",
                  {71'd0, bs_capture}, {71'd0, (m_st == S_CDR && m_boundary())});
            check(bs_update === (m_st == S_UDR && m_floats()), "R9", "bs_update",
                  {71'd0, bs_update}, {71'd0, (m_st == S_UDR && m_floats())});
        end
    endtask

    // from Run-Test/Idle: load an opcode, return to Run-Test/Idle
    task automatic load_ir(input logic [2:0] op, output logic [2:0] seen, output logic hiz_exit);
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 3; i++) begin
            seen[i] = s_tdo;
            step(i == 2, op[i]);
        end
        hiz_exit = s_hiz;
        step(1, 0);
        step(0, 0);
    endtask

    // from Run-Test/Idle: n-bit data scan, return to Run-Test/Idle
    task automatic scan_dr(input int n, input logic [71:0] din, output logic [71:0] dout,
                           output logic cap_seen, output logic upd_seen);
        dout = '0;
        step(1, 0);
        step(0, 0);
        cap_seen = s_cap;
        step(0, 0);
        for (int i = 0; i < n; i++) begin
            dout[i] = s_tdo;
            step(i == n - 1, din[i]);
        end
        step(1, 0);
        upd_seen = s_upd;
        step(0, 0);
    endtask

    initial begin
        #(PER * 150000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [2:0]  seen;
        logic        hz;
        logic [71:0] dout;
        logic        cs, us;
        logic [BW-1:0] pat;
        logic [2:0] byp_ops [4];

        repeat (3) step(1, 0);
        rst = 1'b0;
        step(1, 0);
        // R1: reset state
        check(s_en === 1'b0, "R1", "tdo_en after reset", {71'd0, s_en}, 72'd0);
        check(s_hiz === 1'b0, "R1", "out_hiz after reset", {71'd0, s_hiz}, 72'd0);
        step(0, 0);

        // R4: identification word, active from reset
        cur_req = "R4";
        scan_dr(32, 72'h0, dout, cs, us);
        check(dout[31:0] === ID_EXP, "R4", "id word", dout, {40'd0, ID_EXP});
        check(cs === 1'b0, "R9", "no capture strobe for id", {71'd0, cs}, 72'd0);

        // R3 and R6: load 000
        cur_req = "R3";
        load_ir(3'b000, seen, hz);
        check(seen === 3'b001, "R3", "ir capture pattern", {69'd0, seen}, 72'd1);
        check(hz === 1'b0, "R3", "op unchanged before update", {71'd0, hz}, 72'd0);
        check(s_hiz === 1'b1, "R6", "hiz under 000", {71'd0, s_hiz}, 72'd1);

        cur_req = "R6";
        pat = {5'h15, 64'hDEAD_BEEF_0123_4567};
        io_in = pat;
        scan_dr(70, {3'd0, 69'h0_0F0F_1234_5678_9ABC}, dout, cs, us);
        io_in = ~pat;
        check(dout[BW-1:0] === pat, "R6", "boundary capture", dout, {3'd0, pat});
        check(dout[69] === 1'b0 ^ 1'b0 ^ 1'b0, "R6", "70th shift returns first input bit",
              {71'd0, dout[69]}, 72'd0);
        check(cs === 1'b1 && us === 1'b1, "R9", "strobes under 000", {70'd0, cs, us}, 72'd3);

        // R7: SAMPLE Z style code 010
        cur_req = "R7";
        load_ir(3'b010, seen, hz);
        check(s_hiz === 1'b1, "R7", "hiz under 010", {71'd0, s_hiz}, 72'd1);
        pat = {5'h0A, 64'h1357_9BDF_2468_ACE0};
        io_in = pat;
        scan_dr(69, 72'hFF_FFFF_FFFF_FFFF_FFFF, dout, cs, us);
        check(dout[BW-1:0] === pat, "R7", "boundary capture", dout, {3'd0, pat});
        check(us === 1'b1, "R9", "update strobe under 010", {71'd0, us}, 72'd1);

        // R8: sampling code 100
        cur_req = "R8";
        load_ir(3'b100, seen, hz);
        check(seen === 3'b001, "R3", "ir capture pattern again", {69'd0, seen}, 72'd1);
        check(s_hiz === 1'b0, "R8", "hiz released under 100", {71'd0, s_hiz}, 72'd0);
        pat = {5'h1F, 64'h0000_FFFF_A5A5_5A5A};
        io_in = pat;
        scan_dr(69, 72'h0, dout, cs, us);
        check(dout[BW-1:0] === pat, "R8", "boundary capture", dout, {3'd0, pat});
        check(cs === 1'b1, "R9", "capture strobe under 100", {71'd0, cs}, 72'd1);
        check(us === 1'b0, "R8", "no update strobe", {71'd0, us}, 72'd0);

        // R5: bypass and reserved codes
        cur_req = "R5";
        byp_ops[0] = 3'b111; byp_ops[1] = 3'b011; byp_ops[2] = 3'b101; byp_ops[3] = 3'b110;
        for (int k = 0; k < 4; k++) begin
            load_ir(byp_ops[k], seen, hz);
            check(s_hiz === 1'b0, "R5", "no hiz for bypass code", {71'd0, s_hiz}, 72'd0);
            scan_dr(8, 72'hB7 ^ k, dout, cs, us);
            check(dout[7:0] === {7'(8'hB7 ^ k), 1'b0}, "R5", "one-bit delay with zero capture",
                  dout, {64'd0, 7'(8'hB7 ^ k), 1'b0});
            check(cs === 1'b0 && us === 1'b0, "R9", "no boundary strobes in bypass",
                  {70'd0, cs, us}, 72'd0);
        end

        // R2 and R11: five high mode-select samples from inside a data shift
        cur_req = "R2";
        load_ir(3'b000, seen, hz);
        step(1, 0); step(0, 0); step(0, 1);
        check(s_en === 1'b1, "R10", "enabled in shift", {71'd0, s_en}, 72'd1);
        for (int i = 0; i < 5; i++) step(1, 0);
        check(s_en === 1'b0, "R2", "output disabled after five highs", {71'd0, s_en}, 72'd0);
        check(s_hiz === 1'b1, "R11", "hiz held on entry", {71'd0, s_hiz}, 72'd1);
        cur_req = "R11";
        step(1, 0);
        check(s_hiz === 1'b0, "R11", "hiz released in reset state", {71'd0, s_hiz}, 72'd0);
        step(0, 0);
        cur_req = "R2";
        scan_dr(32, 72'h0, dout, cs, us);
        check(dout[31:0] === ID_EXP, "R2", "id after reset by mode select", dout, {40'd0, ID_EXP});

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule